// File: doc/BRIEF.md
# Shared-Port Pipeline Stall Controller

This block sequences instruction-valid tokens through a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) in which instruction fetch and data access share one memory port. Whenever the instruction in the memory stage needs a data access, that access owns the port for the cycle. The fetch that would have used the port waits. The front end (fetch and decode) freezes for that cycle, and an empty slot is pushed into execute. Nothing is duplicated: the port conflict is settled purely by stalling.

A run begins with a start pulse that carries a program length. Cycle 0 is the first clock cycle after the start is accepted. In every fetch cycle the block shows the index of the instruction it is fetching, and the environment answers on `instr_mem` whether that instruction touches memory. When every instruction touches memory, the completion times follow the alternating +1/+3 pattern, which gives half the unstalled throughput. When no instruction touches memory, the pipeline retires one instruction per cycle once it has filled. After the last write-back the block raises `done` and holds the cycle index of that write-back.

Top module: `shport_stall_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears every stage token and its cycle counter. After such an edge, `stage_occ`, `retire`, `port_to_data`, `port_to_fetch`, `fetch_stall`, `done`, `cycle_cnt` and `fetch_idx` all read zero.
- R2: `stage_occ` bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory and bit 4 write-back. Without conflicts, a token moves one stage per clock. For a program of length n in which no instruction touches memory, instruction k (1-based) retires, with `retire` high, in cycle 3+k.
- R3: In any cycle in which the memory stage holds an instruction whose flag was set, `port_to_data` is 1 and no fetch occurs (`stage_occ[0]` and `port_to_fetch` are 0). `fetch_stall` is 1 in exactly those cycles while instructions remain to be fetched.
- R4: In a conflict cycle, an instruction in decode stays in decode for the next cycle, and execute is empty in the next cycle.
- R5: When every instruction touches memory, instruction 1 retires in cycle 4. Instruction i retires 1 cycle after instruction i-1 for even i, and 3 cycles after it for odd i.
- R6: An instruction whose flag is clear never takes the port in the memory stage and causes no stall.
- R7: In the cycle after the last retire, `done` rises. From then on `cycle_cnt` holds the index of the last retire cycle, until the next accepted start.
- R8: A start pulse that arrives while a run is in progress is ignored, and the run's timing is unchanged.
- R9: A start with program length 0 sets `done` in the next cycle with `cycle_cnt` at 0, and nothing is fetched.
- R10: `fetch_idx` gives the 0-based index of the instruction fetched in the current cycle and runs 0 to n-1 across the fetch cycles. `instr_mem` is sampled only in fetch cycles, as the flag of that instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; accepted only when no run is active |
| prog_len | input | LEN_W | Number of instructions in the run, latched at start |
| instr_mem | input | 1 | Memory-access flag of the instruction at `fetch_idx` |
| fetch_idx | output | LEN_W | Index of the next instruction to fetch |
| stage_occ | output | 5 | Token valid per stage, bit 0 fetch to bit 4 write-back |
| port_to_data | output | 1 | Memory port granted to the memory stage this cycle |
| port_to_fetch | output | 1 | Memory port used by a fetch this cycle |
| fetch_stall | output | 1 | A fetch was wanted but held off by a data access |
| retire | output | 1 | An instruction is in write-back this cycle |
| done | output | 1 | The run has completed |
| cycle_cnt | output | CYC_W | Current cycle index of the run; after completion, the index of the last retire |

## Verification
The assertions take it for granted that `instr_mem` is a settled function of `fetch_idx` during fetch cycles. They also assume that `prog_len` matters only in the cycle in which a start is accepted. The bench keeps to this by driving `instr_mem` from a fixed per-run flag vector indexed by `fetch_idx`. It changes `start` and `prog_len` only on the falling clock edge. It restores `prog_len` after the ignored mid-run start. Each run's timing is checked against retire cycles worked out by hand from the stall rule, for no-memory, all-memory, single-conflict and alternating flag patterns.

// File: rtl/shp_pkg.sv
`timescale 1ns/1ps
// Package: shared stage indices and the per-stage token type for the
// shared-port stall controller. Assumes a fixed five-stage in-order pipe.
package shp_pkg;
    localparam int STG_IF  = 0;
    localparam int STG_ID  = 1;
    localparam int STG_EX  = 2;
    localparam int STG_ME  = 3;
    localparam int STG_WB  = 4;
    localparam int NUM_STG = 5;

    // One pipeline slot: token valid plus the instruction's memory flag.
    typedef struct packed {
        logic vld;
        logic mem;
    } slot_t;
endpackage

// File: rtl/shp_run_ctl.sv
`timescale 1ns/1ps
// Run control: accepts a start when idle, latches the program length,
// counts cycles of the run and retired instructions, and raises done
// after the final retire while holding the cycle index of that retire.
// Assumes retire is high only for valid tokens leaving write-back.
module shp_run_ctl #(
    parameter int LEN_W = 8,
    parameter int CYC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] prog_len,
    input  logic             retire,
    output logic             launch,
    output logic             running,
    output logic             done,
    output logic [LEN_W-1:0] len_q,
    output logic [CYC_W-1:0] cyc
);
    logic             running_q;
    logic             done_q;
    logic [CYC_W-1:0] cyc_q;
    logic [LEN_W-1:0] len_r;
    logic [LEN_W-1:0] ret_q;
    logic             last_ret;

    // Accept a start only while no run is active.
    assign launch = start && !running_q;

    // The retire in this cycle is the final one of the run.
    assign last_ret = retire && (({1'b0, ret_q} + 1'b1) == {1'b0, len_r});

    // Run state, cycle counter and retire counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            done_q    <= 1'b0;
            cyc_q     <= '0;
            len_r     <= '0;
            ret_q     <= '0;
        end else if (launch) begin
            len_r     <= prog_len;
            cyc_q     <= '0;
            ret_q     <= '0;
            running_q <= (prog_len != '0);
            done_q    <= (prog_len == '0);
        end else if (running_q) begin
            if (last_ret) begin
                running_q <= 1'b0;
                done_q    <= 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
                if (retire) begin
                    ret_q <= ret_q + 1'b1;
                end
            end
        end
    end

    assign running = running_q;
    assign done    = done_q;
    assign len_q   = len_r;
    assign cyc     = cyc_q;

    // R7
    property done_hold_p;
        @(posedge clk) disable iff (!rst_n)
            (done_q && !start) |=> (done_q && $stable(cyc_q));
    endproperty
    done_hold_chk: assert property (done_hold_p);

    // R7
    property done_excl_p;
        @(posedge clk) disable iff (!rst_n)
            running_q |-> !done_q;
    endproperty
    done_excl_chk: assert property (done_excl_p);
endmodule

// File: rtl/shp_fetch_seq.sv
`timescale 1ns/1ps
// Fetch sequencer: issues one fetch per cycle while instructions remain,
// unless the memory stage holds the shared port. Fetch is a single-cycle
// slot (no fetch register); the fetched flag goes straight into decode.
// Assumes len_q is stable while running is high.
module shp_fetch_seq #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             running,
    input  logic [LEN_W-1:0] len_q,
    input  logic             stall,
    output logic             fetch_fire,
    output logic             fetch_wait,
    output logic [LEN_W-1:0] fetch_idx
);
    logic [LEN_W-1:0] fcnt_q;
    logic             more;

    // Instructions remain to be fetched in this run.
    assign more       = running && (fcnt_q != len_q);
    assign fetch_fire = more && !stall;
    assign fetch_wait = more && stall;
    assign fetch_idx  = fcnt_q;

    // Count fetches issued in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q <= '0;
        end else if (launch) begin
            fcnt_q <= '0;
        end else if (fetch_fire) begin
            fcnt_q <= fcnt_q + 1'b1;
        end
    end

    // R10
    property fcnt_bound_p;
        @(posedge clk) disable iff (!rst_n)
            running |-> (fcnt_q <= len_q);
    endproperty
    fcnt_bound_chk: assert property (fcnt_bound_p);
endmodule

// File: rtl/shp_stage_pipe.sv
`timescale 1ns/1ps
// Stage token pipe: holds decode, execute and memory slots plus the
// write-back valid bit. A data access in the memory stage freezes the
// decode slot and pushes an empty slot into execute; later stages keep
// moving. Assumes clear is raised for one cycle when a run launches.
module shp_stage_pipe
    import shp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic if_vld,
    input  logic if_mem,
    output logic stall,
    output logic id_vld,
    output logic ex_vld,
    output logic me_vld,
    output logic wb_vld
);
    slot_t slot_q [STG_ID:STG_ME];
    slot_t if_slot;
    logic  wb_q;

    assign if_slot.vld = if_vld;
    assign if_slot.mem = if_mem && if_vld;

    // Port conflict: memory-stage instruction owns the shared port.
    assign stall = slot_q[STG_ME].vld && slot_q[STG_ME].mem;

    for (genvar s = STG_ID; s <= STG_ME; s++) begin : g_stg
        slot_t nxt;
        if (s == STG_ID) begin : g_id
            // Decode holds during a conflict, else takes the fetch slot.
            assign nxt = stall ? slot_q[s] : if_slot;
        end else if (s == STG_EX) begin : g_ex
            // Execute receives a bubble during a conflict.
            assign nxt = stall ? slot_t'('0) : slot_q[s-1];
        end else begin : g_tail
            // Memory stage always advances from execute.
            assign nxt = slot_q[s-1];
        end

        // Slot register for this stage.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                slot_q[s] <= '0;
            end else begin
                slot_q[s] <= nxt;
            end
        end
    end

    // Write-back valid follows the memory stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wb_q <= 1'b0;
        end else begin
            wb_q <= slot_q[STG_ME].vld;
        end
    end

    assign id_vld = slot_q[STG_ID].vld;
    assign ex_vld = slot_q[STG_EX].vld;
    assign me_vld = slot_q[STG_ME].vld;
    assign wb_vld = wb_q;

    // R4
    property id_freeze_p;
        @(posedge clk) disable iff (!rst_n)
            (stall && slot_q[STG_ID].vld && !clear) |=> slot_q[STG_ID].vld;
    endproperty
    id_freeze_chk: assert property (id_freeze_p);

    // R2
    property ex_to_me_p;
        @(posedge clk) disable iff (!rst_n)
            (slot_q[STG_EX].vld && !clear) |=> slot_q[STG_ME].vld;
    endproperty
    ex_to_me_chk: assert property (ex_to_me_p);

    // R2
    property me_to_wb_p;
        @(posedge clk) disable iff (!rst_n)
            (slot_q[STG_ME].vld && !clear) |=> wb_q;
    endproperty
    me_to_wb_chk: assert property (me_to_wb_p);
endmodule

// File: rtl/shport_stall_ctl.sv
`timescale 1ns/1ps
// Top: five-stage token controller with one memory port shared by fetch
// and the memory stage. Ties run control, fetch sequencing and the stage
// pipe together. Assumes instr_mem is the flag of the instruction at
// fetch_idx whenever a fetch takes place.
module shport_stall_ctl
    import shp_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CYC_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [LEN_W-1:0]     prog_len,
    input  logic                 instr_mem,
    output logic [LEN_W-1:0]     fetch_idx,
    output logic [NUM_STG-1:0]   stage_occ,
    output logic                 port_to_data,
    output logic                 port_to_fetch,
    output logic                 fetch_stall,
    output logic                 retire,
    output logic                 done,
    output logic [CYC_W-1:0]     cycle_cnt
);
    logic             launch;
    logic             running;
    logic [LEN_W-1:0] len_q;
    logic             stall;
    logic             fetch_fire;
    logic             fetch_wait;
    logic             id_vld;
    logic             ex_vld;
    logic             me_vld;
    logic             wb_vld;

    shp_run_ctl #(
        .LEN_W (LEN_W),
        .CYC_W (CYC_W)
    ) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .prog_len (prog_len),
        .retire   (wb_vld),
        .launch   (launch),
        .running  (running),
        .done     (done),
        .len_q    (len_q),
        .cyc      (cycle_cnt)
    );

    shp_fetch_seq #(
        .LEN_W (LEN_W)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .running    (running),
        .len_q      (len_q),
        .stall      (stall),
        .fetch_fire (fetch_fire),
        .fetch_wait (fetch_wait),
        .fetch_idx  (fetch_idx)
    );

    shp_stage_pipe u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (launch),
        .if_vld (fetch_fire),
        .if_mem (instr_mem),
        .stall  (stall),
        .id_vld (id_vld),
        .ex_vld (ex_vld),
        .me_vld (me_vld),
        .wb_vld (wb_vld)
    );

    // Gather per-stage occupancy in stage order.
    always_comb begin
        stage_occ          = '0;
        stage_occ[STG_IF]  = fetch_fire;
        stage_occ[STG_ID]  = id_vld;
        stage_occ[STG_EX]  = ex_vld;
        stage_occ[STG_ME]  = me_vld;
        stage_occ[STG_WB]  = wb_vld;
    end

    assign port_to_data  = stall;
    assign port_to_fetch = fetch_fire;
    assign fetch_stall   = fetch_wait;
    assign retire        = wb_vld;

    // R3
    property port_excl_p;
        @(posedge clk) disable iff (!rst_n)
            stall |-> !fetch_fire;
    endproperty
    port_excl_chk: assert property (port_excl_p);

    // R7
    property retire_in_run_p;
        @(posedge clk) disable iff (!rst_n)
            wb_vld |-> running;
    endproperty
    retire_in_run_chk: assert property (retire_in_run_p);
endmodule

// File: tb/shport_stall_ctl_bench.sv
`timescale 1ns/1ps
module shport_stall_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  prog_len;
    logic        instr_mem;
    logic [7:0]  fetch_idx;
    logic [4:0]  stage_occ;
    logic        port_to_data;
    logic        port_to_fetch;
    logic        fetch_stall;
    logic        retire;
    logic        done;
    logic [23:0] cycle_cnt;
    logic [15:0] flag_vec;

    int n_chk = 0;
    int n_bad = 0;
    int wd_cnt = 0;

    always #10 clk = ~clk;

    shport_stall_ctl u_shport_stall_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .prog_len      (prog_len),
        .instr_mem     (instr_mem),
        .fetch_idx     (fetch_idx),
        .stage_occ     (stage_occ),
        .port_to_data  (port_to_data),
        .port_to_fetch (port_to_fetch),
        .fetch_stall   (fetch_stall),
        .retire        (retire),
        .done          (done),
        .cycle_cnt     (cycle_cnt)
    );

    assign instr_mem = flag_vec[fetch_idx[3:0]];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt == 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", wd_cnt);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // One run: checks retire cycles, port use, freezes, fetch order, done.
    task automatic run_prog(input string tag, input int len, input logic [15:0] flags,
                            input int exp_t[8], input int exp_grant,
                            input int exp_fstall, input int restart_at);
        int got[8];
        int nret = 0;
        int ngrant = 0;
        int nfs = 0;
        int nv_port = 0;
        int nv_frz = 0;
        int fidx_bad = 0;
        int nfetch = 0;
        int k = 0;
        logic prev_conf = 1'b0;
        for (int i = 0; i < 8; i++) got[i] = -1;
        flag_vec = flags;
        @(negedge clk);
        start = 1'b1;
        prog_len = len[7:0];
        @(negedge clk);
        start = 1'b0;
        while (!done && k < 400) begin
            if (k == restart_at) begin
                start = 1'b1;
                prog_len = 8'd0;
            end else if (k == restart_at + 1) begin
                start = 1'b0;
                prog_len = len[7:0];
            end
            if (prev_conf && (!stage_occ[1] || stage_occ[2])) nv_frz++;
            prev_conf = port_to_data && stage_occ[1];
            if (port_to_data) ngrant++;
            if (port_to_data && (stage_occ[0] || port_to_fetch)) nv_port++;
            if (fetch_stall) nfs++;
            if (stage_occ[0]) begin
                if (fetch_idx != nfetch[7:0]) fidx_bad++;
                nfetch++;
            end
            if (retire) begin
                if (nret < 8) got[nret] = k;
                nret++;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk(nret == len, {tag, " retire count"}, nret, len);
        for (int i = 0; i < len && i < 8; i++)
            chk(got[i] == exp_t[i], {tag, " retire cycle"}, got[i], exp_t[i]);
        chk(ngrant == exp_grant, "R3/R6 data grant cycles", ngrant, exp_grant);
        chk(nfs == exp_fstall, "R3 fetch stall cycles", nfs, exp_fstall);
        chk(nv_port == 0, "R3 fetch during data access", nv_port, 0);
        chk(nv_frz == 0, "R4 decode freeze and bubble", nv_frz, 0);
        chk(fidx_bad == 0 && nfetch == len, "R10 fetch index order", nfetch, len);
        chk(done == 1'b1, "R7 done raised", done, 1);
        chk(cycle_cnt == exp_t[len-1], "R7 final cycle", cycle_cnt, exp_t[len-1]);
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && cycle_cnt == exp_t[len-1], "R7 count held", cycle_cnt, exp_t[len-1]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(stage_occ == 5'd0 && retire == 1'b0, "R1 stages clear", stage_occ, 0);
        chk(done == 1'b0 && cycle_cnt == 24'd0, "R1 done and count", cycle_cnt, 0);
        chk(port_to_data == 1'b0 && port_to_fetch == 1'b0 && fetch_stall == 1'b0 && fetch_idx == 8'd0,
            "R1 port outputs", port_to_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_nomem();
        int e[8] = '{4, 5, 6, 7, 0, 0, 0, 0};
        run_prog("R2 R6 no-memory", 4, 16'h0000, e, 0, 0, -10);
    endtask

    task automatic t_allmem();
        int e[8] = '{4, 5, 8, 9, 12, 13, 0, 0};
        run_prog("R5 all-memory", 6, 16'h003f, e, 6, 4, -10);
    endtask

    task automatic t_single();
        int e[8] = '{4, 5, 7, 8, 9, 0, 0, 0};
        run_prog("R4 single conflict", 5, 16'h0001, e, 1, 1, -10);
    endtask

    task automatic t_alternate();
        int e[8] = '{4, 5, 7, 8, 0, 0, 0, 0};
        run_prog("R6 alternating", 4, 16'h0005, e, 2, 1, -10);
    endtask

    task automatic t_restart();
        int e[8] = '{4, 5, 8, 9, 12, 13, 0, 0};
        run_prog("R8 start ignored", 6, 16'h003f, e, 6, 4, 5);
    endtask

    task automatic t_empty();
        @(negedge clk);
        start = 1'b1;
        prog_len = 8'd0;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && cycle_cnt == 24'd0, "R9 empty done", cycle_cnt, 0);
        chk(stage_occ == 5'd0, "R9 nothing fetched", stage_occ, 0);
        repeat (2) @(negedge clk);
        chk(stage_occ == 5'd0 && done == 1'b1, "R9 stays idle", stage_occ, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        prog_len = 8'd0;
        flag_vec = 16'h0000;
        t_reset();
        t_nomem();
        t_allmem();
        t_single();
        t_alternate();
        t_restart();
        t_empty();
        t_nomem();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule